// File: doc/BRIEF.md
# Dependent-Instruction Issue Grouper

This block sits between an instruction decoder and a multi-stage execution pipeline. The pipeline stages are, in order: workspace-local load, non-local address, data-cache read, ALU/FPU operation and write. The block takes decoded stack instructions one at a time, each with a byte length and a class tag. It packs runs of consecutive instructions into one issue group, so that a short chain such as two local loads followed by an add leaves as a single pipeline slot.

A group stays open while each new instruction fits. An instruction fits when the group stays within the byte budget and within every per-stage resource count, and when the instruction does not belong to an earlier stage than one the group already occupies. An instruction that does not fit closes the open group and starts the next one. Jumps and unrecognised instructions end a group. The open group is also sent whenever the output is free and no instruction is accepted in that cycle. Each group leaves as one descriptor on a valid/ready output. The descriptor holds the instruction count, the total bytes and a count for each class of resource.

Top module: `insn_grouper`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Class codes on `in_cls` are: 0 local load (local stage), 1 non-local address (address stage), 2 cache read (cache stage), 3 ALU/FPU operation (ALU stage), 4 write (write stage), 5 fused cache-read-and-operate, 6 jump, 7 unknown. A run that keeps stage order and limits forms one group. For example, classes 0,0,3 with 1 byte each give count 3, bytes 3, nloc 2, nop 1.
- R3: The bytes in a group never exceed MAX_BYTES (8). An instruction that would push the total past 8 begins the next group. A total of exactly 8 is allowed.
- R4: A group holds at most 2 local loads, 2 address calculations, 2 cache reads, 1 operation and 1 write. An instruction that would exceed any of these limits begins the next group.
- R5: An instruction whose first stage comes before the last stage already used by the group begins the next group.
- R6: A fused instruction (class 5) counts as one cache read and one operation. It starts in the cache stage and leaves the group at the ALU stage.
- R7: A jump (class 6) uses the operation slot, and the group is sent right after it. An unknown instruction (class 7) always forms a group of its own, with count 1 and all class counts 0.
- R8: In any cycle where the output is free and no instruction is accepted, the open group is sent as a descriptor.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the descriptor and `out_valid` hold their values.
- R10: Groups are sent in input order. Each descriptor has 1 <= `out_count` <= `out_bytes`, and its class counts match the instructions in the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_ready | output | 1 | The block accepts the offered instruction |
| in_cls | input | 3 | Class code (see R2) |
| in_len | input | 4 | Instruction length in bytes, 1 to 8 |
| out_valid | output | 1 | A group descriptor is presented |
| out_ready | input | 1 | The pipeline takes the descriptor |
| out_count | output | 4 | Instructions in the group |
| out_bytes | output | 4 | Total bytes in the group |
| out_nloc | output | 4 | Local loads in the group |
| out_nadr | output | 4 | Address calculations in the group |
| out_ncache | output | 4 | Cache reads in the group |
| out_nop | output | 4 | ALU/FPU operations in the group |
| out_nwr | output | 4 | Writes in the group |

## Verification
The hardest case to reach is a single accepted instruction that must produce two groups. This happens when a jump or unknown instruction arrives while a group is open and does not fit: the old group leaves at once, and the new one is held sealed until the next event. The case is harder to hit when the output stalls at the same moment. Directed bursts place jumps and unknown instructions directly behind open groups. The random phase mixes all eight classes with a stalling `out_ready`, and a bench model that tracks groups as events predicts every descriptor in order.

// File: rtl/grp_pkg.sv
package grp_pkg;
  localparam int NCLS = 5;  // resource index: 0 loc, 1 adr, 2 cache, 3 op, 4 wr

  typedef enum logic [2:0] {
    C_LOCAL = 3'd0, C_ADDR = 3'd1, C_CACHE = 3'd2, C_OPER = 3'd3,
    C_WRITE = 3'd4, C_FUSED = 3'd5, C_JUMP = 3'd6, C_UNK = 3'd7
  } cls_e;

  function automatic logic [2:0] first_stage(cls_e c);
    case (c)
      C_LOCAL: return 3'd0;
      C_ADDR:  return 3'd1;
      C_CACHE, C_FUSED: return 3'd2;
      C_OPER, C_JUMP:   return 3'd3;
      C_WRITE: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] last_stage(cls_e c);
    return (c == C_FUSED) ? 3'd3 : first_stage(c);
  endfunction

  function automatic logic [NCLS-1:0] class_use(cls_e c);
    logic [NCLS-1:0] u;
    u = '0;
    u[0] = (c == C_LOCAL);
    u[1] = (c == C_ADDR);
    u[2] = (c == C_CACHE) || (c == C_FUSED);
    u[3] = (c == C_OPER) || (c == C_FUSED) || (c == C_JUMP);
    u[4] = (c == C_WRITE);
    return u;
  endfunction

  function automatic logic closes_group(cls_e c);
    return (c == C_JUMP) || (c == C_UNK);
  endfunction
endpackage

// File: rtl/grp_fit.sv
module grp_fit
  import grp_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LIM_LOC = 2,
  parameter int LIM_ADDR = 2,
  parameter int LIM_CACHE = 2,
  parameter int LIM_OP = 1,
  parameter int LIM_WR = 1,
  parameter int CNT_W = 4
) (
  input  logic                        acc_sealed,
  input  logic [2:0]                  acc_last,
  input  logic [CNT_W-1:0]            acc_bytes,
  input  logic [NCLS-1:0][CNT_W-1:0]  acc_cnt,
  input  cls_e                        cls,
  input  logic [CNT_W-1:0]            len,
  output logic                        fits,
  output logic [NCLS-1:0]             use_v
);
  localparam int LIM [NCLS] = '{LIM_LOC, LIM_ADDR, LIM_CACHE, LIM_OP, LIM_WR};

  logic [NCLS-1:0] lim_ok;
  logic            bytes_ok;
  logic            order_ok;

  assign use_v = class_use(cls);

  for (genvar k = 0; k < NCLS; k++) begin : g_lim
    assign lim_ok[k] = ({1'b0, acc_cnt[k]} + (CNT_W+1)'(use_v[k])) <= (CNT_W+1)'(LIM[k]);
  end

  assign bytes_ok = ({1'b0, acc_bytes} + {1'b0, len}) <= (CNT_W+1)'(MAX_BYTES);
  assign order_ok = first_stage(cls) >= acc_last;
  assign fits = !acc_sealed && (cls != C_UNK) && bytes_ok && order_ok && (&lim_ok);
endmodule

// File: rtl/grp_outreg.sv
module grp_outreg #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else if (load) begin
      q_valid <= d_valid;
      if (d_valid) q <= d;
    end
  end
endmodule

// File: rtl/insn_grouper.sv
module insn_grouper
  import grp_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LIM_LOC = 2,
  parameter int LIM_ADDR = 2,
  parameter int LIM_CACHE = 2,
  parameter int LIM_OP = 1,
  parameter int LIM_WR = 1,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_cls,
  input  logic [CNT_W-1:0] in_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CNT_W-1:0] out_count,
  output logic [CNT_W-1:0] out_bytes,
  output logic [CNT_W-1:0] out_nloc,
  output logic [CNT_W-1:0] out_nadr,
  output logic [CNT_W-1:0] out_ncache,
  output logic [CNT_W-1:0] out_nop,
  output logic [CNT_W-1:0] out_nwr
);
  localparam int DESC_W = (NCLS + 2) * CNT_W;

  // open group state
  logic                       acc_open, acc_sealed;
  logic [2:0]                 acc_last;
  logic [CNT_W-1:0]           acc_n, acc_bytes;
  logic [NCLS-1:0][CNT_W-1:0] acc_cnt;

  // named events
  cls_e            cls;
  logic            out_free, take, fits, join_ev, spill_ev, idle_flush, emit_merged, emit;
  logic            start_new, closer;
  logic [NCLS-1:0] use_v;
  logic [NCLS-1:0][CNT_W-1:0] sgl_cnt, mrg_cnt;
  logic [DESC_W-1:0] desc_acc, desc_mrg, desc_q;

  assign cls      = cls_e'(in_cls);
  assign closer   = closes_group(cls);
  assign out_free = !out_valid || out_ready;
  assign in_ready = out_free;
  assign take     = in_valid && in_ready;

  grp_fit #(
    .MAX_BYTES(MAX_BYTES), .LIM_LOC(LIM_LOC), .LIM_ADDR(LIM_ADDR),
    .LIM_CACHE(LIM_CACHE), .LIM_OP(LIM_OP), .LIM_WR(LIM_WR), .CNT_W(CNT_W)
  ) u_fit (
    .acc_sealed(acc_sealed), .acc_last(acc_last), .acc_bytes(acc_bytes),
    .acc_cnt(acc_cnt), .cls(cls), .len(in_len), .fits(fits), .use_v(use_v)
  );

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    assign sgl_cnt[k] = CNT_W'(use_v[k]);
    assign mrg_cnt[k] = acc_cnt[k] + CNT_W'(use_v[k]);
  end

  assign join_ev     = take && acc_open && fits;
  assign spill_ev    = take && acc_open && !fits;
  assign idle_flush  = out_free && !take && acc_open;
  assign emit_merged = join_ev && closer;
  assign emit        = emit_merged || spill_ev || idle_flush;
  assign start_new   = take && (!acc_open || spill_ev);

  assign desc_acc = {acc_n, acc_bytes, acc_cnt};
  assign desc_mrg = {acc_n + CNT_W'(1), acc_bytes + in_len, mrg_cnt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_open   <= 1'b0;
      acc_sealed <= 1'b0;
      acc_last   <= '0;
      acc_n      <= '0;
      acc_bytes  <= '0;
      acc_cnt    <= '0;
    end else if (start_new) begin
      acc_open   <= 1'b1;
      acc_sealed <= closer;
      acc_last   <= last_stage(cls);
      acc_n      <= CNT_W'(1);
      acc_bytes  <= in_len;
      acc_cnt    <= sgl_cnt;
    end else if (join_ev && !closer) begin
      acc_last   <= last_stage(cls);
      acc_n      <= acc_n + CNT_W'(1);
      acc_bytes  <= acc_bytes + in_len;
      acc_cnt    <= mrg_cnt;
    end else if (emit_merged || idle_flush) begin
      acc_open   <= 1'b0;
      acc_sealed <= 1'b0;
    end
  end

  grp_outreg #(.W(DESC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(out_free), .d_valid(emit),
    .d(emit_merged ? desc_mrg : desc_acc), .q_valid(out_valid), .q(desc_q)
  );

  assign {out_count, out_bytes, out_nwr, out_nop, out_ncache, out_nadr, out_nloc} = desc_q;
endmodule

// File: rtl/insn_grouper_chk.sv
module insn_grouper_chk #(
  parameter int MAX_BYTES = 8,
  parameter int LIM_LOC = 2,
  parameter int LIM_ADDR = 2,
  parameter int LIM_CACHE = 2,
  parameter int LIM_OP = 1,
  parameter int LIM_WR = 1,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_free,
  input logic             acc_open,
  input logic [CNT_W-1:0] out_count,
  input logic [CNT_W-1:0] out_bytes,
  input logic [CNT_W-1:0] out_nloc,
  input logic [CNT_W-1:0] out_nadr,
  input logic [CNT_W-1:0] out_ncache,
  input logic [CNT_W-1:0] out_nop,
  input logic [CNT_W-1:0] out_nwr
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R3
  byte_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bytes <= CNT_W'(MAX_BYTES)) && (out_bytes != '0));

  // R4
  class_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nloc <= CNT_W'(LIM_LOC)) && (out_nadr <= CNT_W'(LIM_ADDR)) &&
                  (out_ncache <= CNT_W'(LIM_CACHE)) && (out_nop <= CNT_W'(LIM_OP)) &&
                  (out_nwr <= CNT_W'(LIM_WR)));

  // R8
  idle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_open && out_free && !in_valid) |=> out_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_count) && $stable(out_bytes) &&
      $stable(out_nloc) && $stable(out_nadr) && $stable(out_ncache) &&
      $stable(out_nop) && $stable(out_nwr));

  // R10
  count_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count != '0) && (out_count <= out_bytes));
endmodule

bind insn_grouper insn_grouper_chk #(
  .MAX_BYTES(MAX_BYTES), .LIM_LOC(LIM_LOC), .LIM_ADDR(LIM_ADDR),
  .LIM_CACHE(LIM_CACHE), .LIM_OP(LIM_OP), .LIM_WR(LIM_WR), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_free(out_free), .acc_open(acc_open),
  .out_count(out_count), .out_bytes(out_bytes), .out_nloc(out_nloc),
  .out_nadr(out_nadr), .out_ncache(out_ncache), .out_nop(out_nop), .out_nwr(out_nwr)
);

// File: tb/insn_grouper_test.sv
module insn_grouper_test;
  localparam int CLK_P = 10;
  localparam int MAXB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_cls = '0;
  logic [3:0] in_len = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [3:0] out_count, out_bytes, out_nloc, out_nadr, out_ncache, out_nop, out_nwr;

  insn_grouper uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_len(in_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_count(out_count), .out_bytes(out_bytes), .out_nloc(out_nloc),
    .out_nadr(out_nadr), .out_ncache(out_ncache), .out_nop(out_nop), .out_nwr(out_nwr)
  );

  always #(CLK_P/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  logic [27:0] expq[$];
  string       tagq[$];

  // bench model of the open group
  bit m_open, m_sealed;
  int m_last, m_n, m_b;
  int m_c[5];

  function automatic int use_of(int c, int k);
    case (k)
      0: return (c == 0) ? 1 : 0;
      1: return (c == 1) ? 1 : 0;
      2: return (c == 2 || c == 5) ? 1 : 0;
      3: return (c == 3 || c == 5 || c == 6) ? 1 : 0;
      default: return (c == 4) ? 1 : 0;
    endcase
  endfunction

  function automatic int lim_of(int k);
    return (k < 3) ? 2 : 1;
  endfunction

  function automatic int stage_in(int c);
    case (c)
      1: return 1;
      2, 5: return 2;
      3, 6: return 3;
      4: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int stage_out(int c);
    return (c == 5) ? 3 : stage_in(c);
  endfunction

  function automatic logic [27:0] pack(int n, int b, int c0, int c1, int c2, int c3, int c4);
    return {4'(n), 4'(b), 4'(c4), 4'(c3), 4'(c2), 4'(c1), 4'(c0)};
  endfunction

  task automatic m_emit(string tag);
    expq.push_back(pack(m_n, m_b, m_c[0], m_c[1], m_c[2], m_c[3], m_c[4]));
    tagq.push_back(tag);
    m_open = 1'b0;
  endtask

  task automatic m_push(int c, int len, string tag);
    bit ok;
    if (m_open) begin
      ok = !m_sealed && (c != 7) && (m_b + len <= MAXB) && (stage_in(c) >= m_last);
      for (int k = 0; k < 5; k++) if (m_c[k] + use_of(c, k) > lim_of(k)) ok = 1'b0;
      if (ok) begin
        m_n++;
        m_b += len;
        for (int k = 0; k < 5; k++) m_c[k] += use_of(c, k);
        m_last = stage_out(c);
        if (c == 6) m_emit(tag);
        return;
      end
      m_emit(tag);
    end
    m_open = 1'b1;
    m_sealed = (c >= 6);
    m_n = 1;
    m_b = len;
    for (int k = 0; k < 5; k++) m_c[k] = use_of(c, k);
    m_last = stage_out(c);
  endtask

  task automatic check(bit ok, string tag, logic [27:0] got, logic [27:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(int c, int len, string tag);
    bit ok;
    @(negedge clk);
    in_valid = 1'b1;
    in_cls = 3'(c);
    in_len = 4'(len);
    m_push(c, len, tag);
    do begin
      #(CLK_P/4);
      ok = in_ready;
      @(posedge clk);
      if (!ok) @(negedge clk);
    end while (!ok);
  endtask

  task automatic end_burst(string tag);
    bit drained;
    @(negedge clk);
    in_valid = 1'b0;
    if (m_open) m_emit(tag);
    drained = 1'b0;
    for (int i = 0; i < 200 && !drained; i++) begin
      @(negedge clk);
      #(CLK_P/4);
      if (expq.size() == 0) drained = 1'b1;
    end
    check(drained, {tag, " drain"}, 28'(expq.size()), 28'd0);
  endtask

  // output monitor: stall stability (R9) and descriptor order/content (R10)
  logic [27:0] held;
  bit prev_stall = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      out_ready <= stall_en ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (rst_n) begin
        logic [27:0] got;
        got = {out_count, out_bytes, out_nwr, out_nop, out_ncache, out_nadr, out_nloc};
        if (prev_stall) check(out_valid && got == held, "R9 hold", got, held);
        if (out_valid && out_ready) begin
          if (expq.size() == 0) check(1'b0, "R10 unexpected group", got, 28'd0);
          else begin
            logic [27:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(got == e, t, got, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        held = got;
      end
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed_0001));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #(CLK_P/4);
    check(!out_valid && in_ready, "R1 reset", {26'd0, out_valid, in_ready}, 28'd1);

    // R2 dependent run: ldl, ldl, add
    send(0, 1, "R2"); send(0, 1, "R2"); send(3, 1, "R2"); end_burst("R2");
    // R3 byte budget: 4+3 fits, +2 spills; exact 8 fits
    send(0, 4, "R3"); send(1, 3, "R3"); send(2, 2, "R3"); end_burst("R3");
    send(0, 4, "R3 exact"); send(3, 4, "R3 exact"); end_burst("R3 exact");
    // R4 class limits
    send(0, 1, "R4"); send(0, 1, "R4"); send(0, 1, "R4"); end_burst("R4");
    send(2, 1, "R4"); send(2, 1, "R4"); send(2, 1, "R4"); end_burst("R4");
    send(3, 1, "R4"); send(3, 1, "R4"); send(4, 1, "R4"); send(4, 1, "R4"); end_burst("R4");
    // R5 stage order
    send(2, 1, "R5"); send(0, 1, "R5"); send(4, 1, "R5"); send(1, 1, "R5"); end_burst("R5");
    // R6 fused
    send(2, 1, "R6"); send(5, 1, "R6"); send(4, 1, "R6"); end_burst("R6");
    send(5, 1, "R6"); send(2, 1, "R6"); send(5, 1, "R6"); send(3, 1, "R6"); end_burst("R6");
    // R7 jump and unknown
    send(0, 1, "R7"); send(6, 2, "R7"); send(0, 1, "R7"); end_burst("R7");
    send(0, 1, "R7"); send(7, 3, "R7"); send(0, 1, "R7"); end_burst("R7");
    send(6, 1, "R7"); send(7, 1, "R7"); send(6, 1, "R7"); end_burst("R7");
    // R8 idle flush of a lone group
    send(1, 2, "R8"); end_burst("R8");

    // random phase with a stalling output
    stall_en = 1'b1;
    for (int b = 0; b < 60; b++) begin
      int n;
      n = 1 + int'($urandom % 12);
      for (int i = 0; i < n; i++) begin
        int c, l;
        c = int'($urandom % 16);
        c = (c < 14) ? (c % 6) : 6 + (c - 14);
        l = (($urandom % 5) == 0) ? 1 + int'($urandom % 8) : 1 + int'($urandom % 3);
        send(c, l, "R10 random");
      end
      end_burst("R10 random");
    end
    stall_en = 1'b0;
    repeat (4) @(posedge clk);
    done = 1'b1;
    report();
  end
endmodule